// File: doc/BRIEF.md
# Monochrome Raster Timing and Scan-Address Generator

This block drives a one-bit-per-pixel monochrome display. From a single pixel clock it produces horizontal sync, vertical sync and a blanking signal, all active high and with fixed timing. It also walks a frame store of 32-bit words and turns the fetched words into a serial pixel stream. At default parameters the visible raster is 1024 pixels by 864 lines, a line is 1280 clocks and a frame is 901 lines. The frame store holds 1024 line images, each 32 words long.

Vertical scrolling needs no memory copy. An origin register selects the store line that appears at the top of the screen. The origin is applied at the first line of vertical blanking, and the scan wraps from the last store line back to line 0. Once per frame, at the end of the vertical sync pulse, a sticky pending flag is set. The interrupt output is that flag gated by a mask bit.

The fetch runs one word ahead of the display. The address of each word is presented for a full word time before the word is needed, so the serializer never waits between words.

Top module: `mono_raster_gen`

## Requirements
- R1: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks (default 1024+12+128+116). `hsync` is high from clock H_VIS+H_FP of the line for H_SYNC clocks. `blank` is high from clock H_VIS to the end of every line.
- R2: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (default 864+0+3+34). `vsync` is high on lines V_VIS+V_FP through V_VIS+V_FP+V_SYNC-1. `blank` is high on every clock of lines V_VIS and above.
- R3: While `blank` is high, `pixel` is 0.
- R4: Word k of a visible line is shown on pixels 32k to 32k+31, with bit 0 leftmost. Its address is line*(H_VIS/32)+k. That address is held on `fetch_addr` for the word time just before the word is displayed, and `fetch_req` pulses for one clock at the start of that word time. `fetch_data` is sampled on the last clock of the word time. Exactly V_VIS*(H_VIS/32) requests are made per frame.
- R5: The top displayed line is store line origin*(STORE_LINES/2^ORG_W), which is origin*4 at default sizes. Later visible lines follow it in increasing store order.
- R6: The origin register is sampled only at the first clock of vertical blanking. A write during a frame changes nothing in that frame and takes effect in the next one.
- R7: The line sequence wraps from store line STORE_LINES-1 to store line 0.
- R8: The pending flag is set on the clock where `vsync` falls, which is the first clock of line V_VIS+V_FP+V_SYNC, once per frame. `irq` equals pending AND mask.
- R9: Control writes use `reg_sel`=1. In that word, `reg_wdata` bit 0 writes the mask and bit 1 = 1 clears the pending flag. If a clear and a set fall in the same clock, the set wins. Origin writes use `reg_sel`=0.
- R10: After reset the raster sits at pixel 0 of line 0, and the origin, mask and pending flag are all 0. `hsync`, `vsync`, `blank`, `pixel` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: origin register, 1: interrupt control |
| reg_wdata | input | ORG_W | Write data |
| fetch_data | input | WORD_W | Word returned from the frame store |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking, active high |
| fetch_req | output | 1 | One-clock pulse at the start of each fetch window |
| fetch_addr | output | ADDR_W | Word address in the frame store |
| pixel | output | 1 | Serial pixel |
| irq | output | 1 | End-of-frame interrupt request |

## Verification
The frame store is modelled as a hashed function of the address, so every word differs and a wrong line, a wrong word order or a reversed bit order shows up as a pixel mismatch. The origin is stepped through several values: a small value, a mid-range value, a value that shifts by a power of two, and the last step before the end of the store. Comparing the displayed lines against the expected lines separates a correct origin multiply from an off-by-one line and from a missing wrap. Each origin is written in the middle of a frame, which shows whether the origin is sampled only at blanking. The interrupt is driven with the mask off, then with the mask on, then with an acknowledge. This separates the sticky flag from the gating, and the one-per-frame event from a level.

// File: rtl/mono_raster_pkg.sv
package mono_raster_pkg;

  typedef enum logic {
    SEL_ORIGIN = 1'b0,
    SEL_IRQCTL = 1'b1
  } reg_sel_e;

  function automatic logic in_win(int x, int lo, int hi);
    return (x >= lo) && (x < hi);
  endfunction

  function automatic int line_step(int line, int lines);
    return (line + 1 >= lines) ? 0 : line + 1;
  endfunction

  function automatic int word_index(int line, int word, int wpl);
    return line * wpl + word;
  endfunction

  function automatic int origin_to_line(int org, int step);
    return org * step;
  endfunction

endpackage

// File: rtl/mono_raster_timing.sv
module mono_raster_timing
  import mono_raster_pkg::*;
#(
  parameter int H_VIS  = 1024,
  parameter int H_FP   = 12,
  parameter int H_SYNC = 128,
  parameter int H_BP   = 116,
  parameter int V_VIS  = 864,
  parameter int V_FP   = 0,
  parameter int V_SYNC = 3,
  parameter int V_BP   = 34,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HCW   = $clog2(H_TOT),
  localparam int VCW   = $clog2(V_TOT)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           hsync,
  output logic           vsync,
  output logic           hblank,
  output logic           vblank,
  output logic           line_end,
  output logic           vblank_start,
  output logic           eof_evt
);

  localparam int HS_BEG = H_VIS + H_FP;
  localparam int HS_END = HS_BEG + H_SYNC;
  localparam int VS_BEG = V_VIS + V_FP;
  localparam int VS_END = VS_BEG + V_SYNC;

  logic frame_last;

  assign line_end     = (int'(hcnt) == H_TOT - 1);
  assign frame_last   = (int'(vcnt) == V_TOT - 1);
  assign vblank_start = line_end && (int'(vcnt) == V_VIS - 1);
  assign eof_evt      = line_end && (int'(vcnt) == VS_END - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign hsync  = in_win(int'(hcnt), HS_BEG, HS_END);
  assign vsync  = in_win(int'(vcnt), VS_BEG, VS_END);
  assign hblank = int'(hcnt) >= H_VIS;
  assign vblank = int'(vcnt) >= V_VIS;

endmodule

// File: rtl/mono_raster_fetch.sv
module mono_raster_fetch
  import mono_raster_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int H_VIS       = 1024,
  parameter int H_TOT       = 1280,
  parameter int V_VIS       = 864,
  parameter int V_TOT       = 901,
  parameter int STORE_LINES = 1024,
  localparam int HCW    = $clog2(H_TOT),
  localparam int VCW    = $clog2(V_TOT),
  localparam int LINE_W = $clog2(STORE_LINES),
  localparam int WPL    = H_VIS / WORD_W,
  localparam int ADDR_W = $clog2(STORE_LINES * WPL),
  localparam int WB     = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HCW-1:0]    hcnt,
  input  logic [VCW-1:0]    vcnt,
  input  logic              line_end,
  input  logic              vblank_start,
  input  logic [LINE_W-1:0] origin_line,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              load_word
);

  // store line shown on the current visible row; during blanking it
  // already holds the top line of the coming frame
  logic [LINE_W-1:0] row_q;
  logic head_win, tail_win, next_vis, next_top, row_vis;
  int   sel_line, sel_word;

  always_comb begin
    row_vis  = int'(vcnt) < V_VIS;
    next_vis = int'(vcnt) < V_VIS - 1;
    next_top = int'(vcnt) == V_TOT - 1;
    head_win = row_vis && (int'(hcnt) < H_VIS - WORD_W);
    tail_win = (int'(hcnt) >= H_TOT - WORD_W) && (next_vis || next_top);
    sel_line = int'(row_q);
    sel_word = int'(hcnt) / WORD_W + 1;
    if (tail_win) begin
      sel_word = 0;
      if (next_vis) sel_line = line_step(int'(row_q), STORE_LINES);
    end
  end

  assign fetch_addr = (head_win || tail_win)
                    ? ADDR_W'(word_index(sel_line, sel_word, WPL)) : '0;

  assign fetch_req = (head_win && (hcnt[WB-1:0] == '0)) ||
                     (tail_win && (int'(hcnt) == H_TOT - WORD_W));

  assign load_word = (line_end && (next_vis || next_top)) ||
                     (row_vis && (int'(hcnt) < H_VIS - 1) && (hcnt[WB-1:0] == '1));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
    end else if (vblank_start) begin
      row_q <= origin_line;
    end else if (line_end && next_vis) begin
      row_q <= LINE_W'(line_step(int'(row_q), STORE_LINES));
    end
  end

endmodule

// File: rtl/mono_raster_shifter.sv
module mono_raster_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  input  logic              blank,
  output logic              pixel
);

  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (load) sh_q <= data;
    else           sh_q <= {1'b0, sh_q[WORD_W-1:1]};
  end

  assign pixel = sh_q[0] & ~blank;

endmodule

// File: rtl/mono_raster_ctl.sv
module mono_raster_ctl
  import mono_raster_pkg::*;
#(
  parameter int ORG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel,
  input  logic [ORG_W-1:0] wdata,
  input  logic             eof_evt,
  output logic [ORG_W-1:0] origin_q,
  output logic             mask_q,
  output logic             pend_q,
  output logic             ack_evt,
  output logic             irq
);

  logic ctl_wr;

  assign ctl_wr  = we && (reg_sel_e'(sel) == SEL_IRQCTL);
  assign ack_evt = ctl_wr && wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      origin_q <= '0;
      mask_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (we && (reg_sel_e'(sel) == SEL_ORIGIN)) origin_q <= wdata;
      if (ctl_wr) mask_q <= wdata[0];
      if (eof_evt)      pend_q <= 1'b1;
      else if (ack_evt) pend_q <= 1'b0;
    end
  end

  assign irq = pend_q & mask_q;

endmodule

// File: rtl/mono_raster_gen.sv
module mono_raster_gen
  import mono_raster_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int H_VIS       = 1024,
  parameter int H_FP        = 12,
  parameter int H_SYNC      = 128,
  parameter int H_BP        = 116,
  parameter int V_VIS       = 864,
  parameter int V_FP        = 0,
  parameter int V_SYNC      = 3,
  parameter int V_BP        = 34,
  parameter int STORE_LINES = 1024,
  parameter int ORG_W       = 8,
  localparam int ADDR_W = $clog2(STORE_LINES * (H_VIS / WORD_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [ORG_W-1:0]  reg_wdata,
  input  logic [WORD_W-1:0] fetch_data,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              pixel,
  output logic              irq
);

  localparam int H_TOT  = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT  = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HCW    = $clog2(H_TOT);
  localparam int VCW    = $clog2(V_TOT);
  localparam int LINE_W = $clog2(STORE_LINES);
  localparam int STEP   = STORE_LINES >> ORG_W;

  logic [HCW-1:0]    hcnt;
  logic [VCW-1:0]    vcnt;
  logic              hblank, vblank;
  logic              line_end, vblank_start, eof_evt;
  logic              load_word;
  logic [ORG_W-1:0]  origin_q;
  logic [LINE_W-1:0] origin_line;
  logic              mask_q, pend_q, ack_evt;

  mono_raster_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .line_end(line_end), .vblank_start(vblank_start), .eof_evt(eof_evt)
  );

  assign blank       = hblank | vblank;
  assign origin_line = LINE_W'(origin_to_line(int'(origin_q), STEP));

  mono_raster_fetch #(
    .WORD_W(WORD_W), .H_VIS(H_VIS), .H_TOT(H_TOT),
    .V_VIS(V_VIS), .V_TOT(V_TOT), .STORE_LINES(STORE_LINES)
  ) u_fetch (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .line_end(line_end), .vblank_start(vblank_start),
    .origin_line(origin_line), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .load_word(load_word)
  );

  mono_raster_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(load_word), .data(fetch_data),
    .blank(blank), .pixel(pixel)
  );

  mono_raster_ctl #(.ORG_W(ORG_W)) u_ctl (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .eof_evt(eof_evt), .origin_q(origin_q), .mask_q(mask_q),
    .pend_q(pend_q), .ack_evt(ack_evt), .irq(irq)
  );

endmodule

// File: rtl/mono_raster_chk.sv
module mono_raster_chk (
  input logic clk,
  input logic rst,
  input logic hsync,
  input logic vsync,
  input logic blank,
  input logic pixel,
  input logic fetch_req,
  input logic irq,
  input logic mask_q,
  input logic pend_q,
  input logic eof_evt,
  input logic ack_evt
);

  p_hsync_in_blank_r1: assert property (@(posedge clk) disable iff (rst)
    hsync |-> blank);

  p_vsync_in_blank_r2: assert property (@(posedge clk) disable iff (rst)
    vsync |-> blank);

  p_dark_when_blank_r3: assert property (@(posedge clk) disable iff (rst)
    blank |-> !pixel);

  p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> !fetch_req);

  p_pend_set_r8: assert property (@(posedge clk) disable iff (rst)
    eof_evt |=> pend_q);

  p_pend_at_vsync_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $fell(vsync));

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> mask_q);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_evt && !eof_evt) |=> !pend_q);

endmodule

bind mono_raster_gen mono_raster_chk u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .blank(blank),
  .pixel(pixel), .fetch_req(fetch_req), .irq(irq), .mask_q(mask_q),
  .pend_q(pend_q), .eof_evt(eof_evt), .ack_evt(ack_evt)
);

// File: tb/mono_raster_gen_tb.sv
`timescale 1ns/1ps
module mono_raster_gen_tb;

  localparam int HV = 64, HFP = 8, HSW = 16, HBP = 8;
  localparam int VV = 8, VFP = 0, VSW = 3, VBP = 4;
  localparam int HT = HV + HFP + HSW + HBP;   // 96
  localparam int VT = VV + VFP + VSW + VBP;   // 15
  localparam int FT = HT * VT;
  localparam int NL = 1024;

  // origin written, expected top store line (origin * 4)
  localparam logic [17:0] TBL [4] = '{
    {8'd3,   10'd12},
    {8'd100, 10'd400},
    {8'd64,  10'd256},
    {8'd255, 10'd1020}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [31:0] fetch_data;
  logic hsync, vsync, blank, fetch_req, pixel, irq;
  logic [10:0] fetch_addr;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] ram_word(int a);
    logic [31:0] av;
    av = 32'(a);
    return (av * 32'h9E3779B1) ^ 32'hC3A50F1E;
  endfunction

  function automatic logic pix_of(int top, int v, int h);
    logic [31:0] w;
    w = ram_word(((top + v) % NL) * 2 + h / 32);
    return w[h % 32];
  endfunction

  assign fetch_data = ram_word(int'(fetch_addr));

  mono_raster_gen #(
    .WORD_W(32), .H_VIS(HV), .H_FP(HFP), .H_SYNC(HSW), .H_BP(HBP),
    .V_VIS(VV), .V_FP(VFP), .V_SYNC(VSW), .V_BP(VBP),
    .STORE_LINES(NL), .ORG_W(8)
  ) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .fetch_data(fetch_data), .hsync(hsync),
    .vsync(vsync), .blank(blank), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .pixel(pixel), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst) t <= 0;
    else     t <= t + 1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic goto(int target);
    while (t < target) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // walk lines vlo..vhi-1 of frame f, comparing pixels; optional origin write
  task automatic scan(int f, int vlo, int vhi, int top, string tag,
                      int wr_t, logic [7:0] wdat);
    int bad, dark, h, v;
    logic e;
    bad = 0; dark = 0;
    goto(f * FT + vlo * HT);
    for (int c = 0; c < (vhi - vlo) * HT; c++) begin
      h = t % HT; v = (t / HT) % VT;
      reg_we = (t == wr_t); reg_sel = 1'b0; reg_wdata = wdat;
      if (v < VV && h < HV) begin
        e = pix_of(top, v, h);
        if (pixel !== e) bad++;
      end else if (pixel !== 1'b0) begin
        dark++;
      end
      @(negedge clk);
    end
    reg_we = 1'b0;
    chk(bad == 0, tag, "pixel mismatches", bad, 0);
    chk(dark == 0, "R3", "lit pixels in blanking", dark, 0);
  endtask

  initial begin
    int hb, vb, bb, reqs, ib, top_prev;
    logic [7:0] org;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(hsync === 1'b0, "R10", "hsync in reset", hsync, 0);
    chk(vsync === 1'b0, "R10", "vsync in reset", vsync, 0);
    chk(blank === 1'b0, "R10", "blank in reset", blank, 0);
    chk(pixel === 1'b0, "R10", "pixel in reset", pixel, 0);
    chk(irq === 1'b0, "R10", "irq in reset", irq, 0);
    rst = 1'b0;

    // frame 0: raster timing, request count, masked interrupt
    hb = 0; vb = 0; bb = 0; reqs = 0; ib = 0;
    for (int c = 0; c < FT; c++) begin
      int h, v;
      h = t % HT; v = (t / HT) % VT;
      if (hsync !== (h >= HV + HFP && h < HV + HFP + HSW)) hb++;
      if (vsync !== (v >= VV + VFP && v < VV + VFP + VSW)) vb++;
      if (blank !== (h >= HV || v >= VV)) bb++;
      if (fetch_req === 1'b1) reqs++;
      if (irq !== 1'b0) ib++;
      @(negedge clk);
    end
    chk(hb == 0, "R1", "hsync mismatches", hb, 0);
    chk(bb == 0, "R2", "blank mismatches", bb, 0);
    chk(vb == 0, "R2", "vsync mismatches", vb, 0);
    chk(reqs == VV * 2, "R4", "requests per frame", reqs, VV * 2);
    chk(ib == 0, "R10", "irq while masked", ib, 0);

    // origin table: write mid-frame, new top appears one frame later
    top_prev = 0;
    for (int i = 0; i < 4; i++) begin
      org = TBL[i][17:10];
      scan(1 + i, 0, 4, top_prev, "R5", -1, 8'd0);
      scan(1 + i, 4, VT, top_prev, "R6", (1 + i) * FT + 4 * HT, org);
      top_prev = int'(TBL[i][9:0]);
    end

    // frame 5 starts at store line 1020 and wraps to line 0 on row 4
    scan(5, 0, 3, top_prev, "R5", -1, 8'd0);
    goto(5 * FT + 3 * HT);
    chk(fetch_req === 1'b1, "R4", "req at head window", fetch_req, 1);
    chk(fetch_addr == 11'd2047, "R7", "addr of line 1023 word 1", fetch_addr, 2047);
    goto(5 * FT + 3 * HT + HT - 32);
    chk(fetch_req === 1'b1, "R4", "req at tail window", fetch_req, 1);
    chk(fetch_addr == 11'd0, "R7", "addr after wrap", fetch_addr, 0);
    scan(5, 4, VT, top_prev, "R7", -1, 8'd0);

    // interrupt: sticky pending, mask gating, acknowledge, once per frame
    goto(6 * FT);
    chk(irq === 1'b0, "R8", "irq with mask 0", irq, 0);
    wr(1'b1, 8'h01);
    chk(irq === 1'b1, "R9", "irq after mask set", irq, 1);
    wr(1'b1, 8'h03);
    chk(irq === 1'b0, "R9", "irq after ack", irq, 0);
    goto(6 * FT + 11 * HT - 1);
    chk(irq === 1'b0 && vsync === 1'b1, "R8", "irq before vsync end", irq, 0);
    @(negedge clk);
    chk(irq === 1'b1 && vsync === 1'b0, "R8", "irq at vsync end", irq, 1);
    wr(1'b1, 8'h03);
    goto(7 * FT + 11 * HT - 1);
    chk(irq === 1'b0, "R8", "no second event in frame", irq, 0);
    @(negedge clk);
    chk(irq === 1'b1, "R8", "event next frame", irq, 1);
    wr(1'b1, 8'h00);
    chk(irq === 1'b0, "R9", "irq after mask clear", irq, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule